// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a down-counting interrupt timer. Software loads a start value, picks a power-of-two prescale for a free-running tick input, and chooses through a control entry whether the timer runs once or repeats, whether it is masked, and which 8-bit vector it raises. Each prescaled tick lowers the live count by one. When the count is already zero and one more prescaled tick arrives, the timer expires. At expiry it emits a one-cycle strobe carrying the vector, unless it is masked.

The live count, the start value, the control entry and the prescale code can all be read back through a registered read port. Priority handling and delivery of the strobe lie outside this block.

Three states order the behaviour. `ST_IDLE` holds from reset until the first load. `ST_RUN` counts. `ST_DONE` is reached when a one-shot timer expires.

The transitions are as follows:
- *load*: a start-value write moves any state to `ST_RUN`.
- *expire*: a one-shot expiry moves `ST_RUN` to `ST_DONE`.
- *resume*: `ST_DONE` returns to `ST_RUN` one cycle after the control entry selects repeating mode.
- *reload*: a repeating expiry keeps the timer in `ST_RUN`.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, reads return the following values. The control entry reads 0x0001_0000, which means masked, one-shot and vector 0. The start value, the live count and the prescale register all read 0. `irq_strobe` is low.
- R2: A write to the prescale register (select 3) keeps only data bits 3, 1 and 0, and reads return them in those positions. Every other bit reads 0.
- R3: The prescale code is v = {bit3, bit1, bit0} and the shift is (v+1) mod 8. One count step happens every 2^shift cycles in which `tick` is high, so the divisor is 2 to 128, or 1 when v = 7. No step occurs while `tick` is low, and a step changes the count by exactly one.
- R4: A write to the start value (select 1) loads the count with the written data, restarts the prescaler from zero and enters `ST_RUN`. This holds in every state and takes priority over a step in the same cycle.
- R5: In one-shot mode (control bit 17 = 0), a step lowers a nonzero count. The count saturates at zero. A step taken at zero expires the timer once and enters `ST_DONE`, so expiry follows start value + 1 steps.
- R6: In repeating mode (control bit 17 = 1), a step at zero reloads the start value and expires the timer. The period is therefore start value + 1 steps.
- R7: In repeating mode with a start value of zero, the timer never expires and the count stays at 0.
- R8: While the mask (control bit 16) is set, counting continues as in R5 and R6, but no strobe is produced.
- R9: An unmasked expiry raises `irq_strobe` for exactly one cycle after the step edge. At the same time `irq_vector` equals control bits 7:0 as written.
- R10: If the control entry is written with repeating mode while the timer is in `ST_DONE`, the timer resumes. From the next cycle, steps follow R6 from a count of 0.
- R11: `rd_data` shows, one cycle later, the register selected by `rd_sel`. The encoding is 0 for control, 1 for start value, 2 for live count and 3 for prescale. Writes to select 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, prescaled before stepping |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | DATA_W | Registered read data |
| irq_strobe | output | 1 | One-cycle expiry pulse |
| irq_vector | output | VEC_W | Vector qualified by `irq_strobe` |

## Verification
The assertions rely on two facts about how the timer is driven. The start value only changes together with a load of the count, and reset is applied synchronously before any write. On those grounds a repeating timer can never expire twice in adjacent cycles, and a zero start value implies a zero count.

The stimulus configures each case one register write per cycle with `tick` held low. It then runs `tick` high for a fixed number of cycles, and lowers it again before reading back. This keeps every check free of steps that overlap a write.

// File: rtl/icd_pkg.sv
`timescale 1ns/1ps
package icd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        SEL_ENTRY  = 2'd0,
        SEL_INIT   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_DIVIDE = 2'd3
    } reg_sel_e;

    localparam int ENTRY_MASK_BIT     = 16;
    localparam int ENTRY_PERIODIC_BIT = 17;

    // shift = (code + 1) mod 8; a 3-bit add wraps naturally
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/icd_prescaler.sv
`timescale 1ns/1ps
module icd_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               restart_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               step_o
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    for (genvar i = 0; i < PRE_W; i++) begin : g_lim
        assign lim[i] = (SHIFT_W'(i) < shift_i);
    end

    assign step_o = tick_i && !restart_i && ((pre_q & lim) == lim);

    always_ff @(posedge clk_i) begin
        if (!rst_ni || restart_i) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R3
    pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart_i && !tick_i) |=> $stable(pre_q));

endmodule

// File: rtl/icd_counter_fsm.sv
`timescale 1ns/1ps
module icd_counter_fsm import icd_pkg::*; #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic             periodic_i,
    input  logic             mask_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fire_o,
    output logic [VEC_W-1:0] vec_o
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             fire_q, fire_d;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        fire_d  = 1'b0;
        if (load_i) begin
            state_d = ST_RUN;
            count_d = load_val_i;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (step_i) begin
                        if (count_q != '0) begin
                            count_d = count_q - CNT_W'(1);
                        end else if (periodic_i) begin
                            if (init_i != '0) begin
                                count_d = init_i;
                                fire_d  = !mask_i;
                            end
                        end else begin
                            fire_d  = !mask_i;
                            state_d = ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (periodic_i) state_d = ST_RUN;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
            fire_q  <= 1'b0;
            vec_q   <= '0;
        end else begin
            count_q <= count_d;
            fire_q  <= fire_d;
            if (fire_d) vec_q <= vec_i;
        end
    end

    assign count_o = count_q;
    assign fire_o  = fire_q;
    assign vec_o   = vec_q;

    // R4
    load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> count_q == $past(load_val_i));

    // R5
    count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && count_q == '0 && !periodic_i) |=> count_q == '0);

    // R3
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && count_q != '0) |=>
        (count_q == $past(count_q)) || (count_q == $past(count_q) - CNT_W'(1)));

    // R7
    zero_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (periodic_i && init_i == '0 && !load_i) |=> !fire_q);

endmodule

// File: rtl/irq_countdown_timer.sv
`timescale 1ns/1ps
module irq_countdown_timer import icd_pkg::*; #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int VEC_W   = 8,
    parameter int SHIFT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_strobe,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [VEC_W-1:0]   vec_q;
    logic               mask_q;
    logic               periodic_q;
    logic [CNT_W-1:0]   init_q;
    logic [SHIFT_W-1:0] code_q;
    logic [CNT_W-1:0]   count;
    logic               step;

    wire entry_wr = wr_en && (wr_sel == SEL_ENTRY);
    wire init_wr  = wr_en && (wr_sel == SEL_INIT);
    wire div_wr   = wr_en && (wr_sel == SEL_DIVIDE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q      <= '0;
            mask_q     <= 1'b1;
            periodic_q <= 1'b0;
            init_q     <= '0;
            code_q     <= '0;
        end else begin
            if (entry_wr) begin
                vec_q      <= wr_data[VEC_W-1:0];
                mask_q     <= wr_data[ENTRY_MASK_BIT];
                periodic_q <= wr_data[ENTRY_PERIODIC_BIT];
            end
            if (init_wr) init_q <= wr_data[CNT_W-1:0];
            if (div_wr)  code_q <= {wr_data[3], wr_data[1:0]};
        end
    end

    icd_prescaler #(.SHIFT_W(SHIFT_W)) u_prescaler (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .restart_i (init_wr),
        .shift_i   (div_shift(code_q)),
        .step_o    (step)
    );

    icd_counter_fsm #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_fsm (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .step_i     (step),
        .load_i     (init_wr),
        .load_val_i (wr_data[CNT_W-1:0]),
        .init_i     (init_q),
        .periodic_i (periodic_q),
        .mask_i     (mask_q),
        .vec_i      (vec_q),
        .count_o    (count),
        .fire_o     (irq_strobe),
        .vec_o      (irq_vector)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= '0;
            unique case (reg_sel_e'(rd_sel))
                SEL_ENTRY: begin
                    rd_data[VEC_W-1:0]         <= vec_q;
                    rd_data[ENTRY_MASK_BIT]     <= mask_q;
                    rd_data[ENTRY_PERIODIC_BIT] <= periodic_q;
                end
                SEL_INIT:   rd_data[CNT_W-1:0] <= init_q;
                SEL_COUNT:  rd_data[CNT_W-1:0] <= count;
                SEL_DIVIDE: begin
                    rd_data[3]   <= code_q[2];
                    rd_data[1:0] <= code_q[1:0];
                end
                default: ;
            endcase
        end
    end

    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> !$past(mask_q));

    // R9
    strb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |=> !irq_strobe);

endmodule

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
module test_irq_countdown_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_strobe;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_countdown_timer i_irq_countdown_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_strobe(irq_strobe), .irq_vector(irq_vector)
    );

    typedef struct packed {
        logic [3:0]  cfg;
        logic        per;
        logic        msk;
        logic [7:0]  vec;
        logic [31:0] init;
        logic [15:0] run;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{4'hB, 1'b0, 1'b0, 8'h31, 32'd5,  16'd10},
        '{4'hB, 1'b0, 1'b0, 8'h42, 32'd20, 16'd7},
        '{4'hB, 1'b1, 1'b0, 8'h55, 32'd3,  16'd13},
        '{4'hB, 1'b1, 1'b0, 8'h66, 32'd0,  16'd10},
        '{4'h0, 1'b0, 1'b0, 8'h77, 32'd4,  16'd9},
        '{4'h0, 1'b0, 1'b0, 8'h78, 32'd4,  16'd10},
        '{4'h3, 1'b1, 1'b0, 8'h80, 32'd2,  16'd100},
        '{4'hB, 1'b1, 1'b1, 8'h90, 32'd3,  16'd20},
        '{4'hA, 1'b0, 1'b0, 8'h99, 32'd1,  16'd300},
        '{4'h8, 1'b0, 1'b0, 8'hA0, 32'd10, 16'd100},
        '{4'hB, 1'b0, 1'b0, 8'h11, 32'd0,  16'd3},
        '{4'h0, 1'b1, 1'b0, 8'hC3, 32'd1,  16'd17}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_sel = sel; wr_data = data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel;
        @(negedge clk);
        val = rd_data;
    endtask

    task automatic run(input int k, input logic [7:0] vec, input string req, output int fires);
        fires = 0;
        tick = 1'b1;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (irq_strobe) begin
                fires++;
                check(req, 32'(irq_vector), 32'(vec));
            end
        end
        tick = 1'b0;
    endtask

    function automatic logic [31:0] entry_word(input logic per, input logic msk, input logic [7:0] vec);
        return {14'd0, per, msk, 8'd0, vec};
    endfunction

    // model from R3, R5, R6, R7, R8
    task automatic model(input vec_t v, output int unsigned cnt, output int unsigned f);
        int unsigned code, s, d;
        code = {v.cfg[3], v.cfg[1:0]};
        s = (code + 1) % 8;
        d = int'(v.run) >> s;
        if (v.per) begin
            if (v.init == 0) begin cnt = 0; f = 0; end
            else begin
                f = d / (v.init + 1);
                cnt = v.init - (d % (v.init + 1));
            end
        end else begin
            cnt = (d >= v.init) ? 0 : v.init - d;
            f = (d >= v.init + 1) ? 1 : 0;
        end
        if (v.msk) f = 0;
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] val;
        int fires;
        int unsigned ecnt, efire;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 strobe", 32'(irq_strobe), 32'd0);
        rd(2'd0, val); check("R1 entry", val, 32'h0001_0000);
        rd(2'd1, val); check("R1 init", val, 32'd0);
        rd(2'd2, val); check("R1 count", val, 32'd0);
        rd(2'd3, val); check("R1 divide", val, 32'd0);

        // R2 divide keeps bits 3,1,0
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, val); check("R2 all ones", val, 32'h0000_000B);
        wr(2'd3, 32'h0000_0004); rd(2'd3, val); check("R2 bit2 dropped", val, 32'd0);

        // R11 writes to live count ignored
        wr(2'd2, 32'd123); rd(2'd2, val); check("R11 count write ignored", val, 32'd0);

        // table of vectors: R3 R5 R6 R7 R8 R9
        for (int n = 0; n < NV; n++) begin
            wr(2'd3, 32'(VT[n].cfg));
            wr(2'd0, entry_word(VT[n].per, VT[n].msk, VT[n].vec));
            wr(2'd1, VT[n].init);
            run(int'(VT[n].run), VT[n].vec, "R9 vector", fires);
            model(VT[n], ecnt, efire);
            rd(2'd2, val);
            check("R5/R6/R3 count", val, ecnt);
            check("R5/R6/R7/R8 fires", 32'(fires), efire);
        end

        // R3 tick low: no steps
        wr(2'd3, 32'hB); wr(2'd0, entry_word(1'b0, 1'b0, 8'h01)); wr(2'd1, 32'd4);
        repeat (10) @(negedge clk);
        rd(2'd2, val); check("R3 tick low", val, 32'd4);

        // R4 init write restarts prescaler (divide by 2)
        wr(2'd3, 32'h0); wr(2'd1, 32'd5);
        run(1, 8'h01, "R4 vector", fires);
        wr(2'd1, 32'd5);
        run(1, 8'h01, "R4 vector", fires);
        rd(2'd2, val); check("R4 prescaler restart", val, 32'd5);
        rd(2'd1, val); check("R11 init readback", val, 32'd5);

        // R10 resume from expired one-shot
        wr(2'd3, 32'hB); wr(2'd0, entry_word(1'b0, 1'b0, 8'h21)); wr(2'd1, 32'd2);
        run(3, 8'h21, "R10 vector", fires); check("R10 one-shot fired", 32'(fires), 32'd1);
        wr(2'd0, entry_word(1'b1, 1'b0, 8'h22));
        @(negedge clk);
        run(1, 8'h22, "R10 vector", fires); check("R10 resume fires", 32'(fires), 32'd1);
        rd(2'd2, val); check("R10 reload", val, 32'd2);
        rd(2'd0, val); check("R11 entry readback", val, 32'h0002_0022);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule